// File: doc/BRIEF.md
# K-Code Framed Packet Receiver

This block sits behind an 8b/10b symbol decoder and turns its stream of decoded symbols into fixed-length packets. Each symbol arrives with a valid strobe and is either a data byte, a control code, or an error mark. Two control codes drive framing. A start code opens a frame and asks the downstream descrambler to reseed. A resync code restarts a frame that is already open. Any other control code closes the frame.

Packet bytes are not stored in a buffer. As each byte arrives, the block folds it into a running CRC-32 and captures only the bytes it needs: the brightness byte for its own address, its own channel-mask byte, and the trailing checksum. When the last byte lands, the block compares the checksum and raises a ready flag. If the checksum matches, it also updates its brightness and channel-mask outputs. Four saturating counters record checksum errors, receive overflows, processing overflows and decode errors.

The packet holds `ceil(NUM_MOD/2)` brightness bytes, then `NUM_MOD` channel-mask bytes, then four checksum bytes. With the defaults (`NUM_MOD`=8, `MOD_ADDR`=5) a packet is 16 bytes long.

Top module: `kframe_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `pkt_ready`, `pkt_crc_ok`, `seed_restart`, `led_level`, `chan_mask` and all four counters are zero.
- R2: A valid control symbol with byte 0x3C (`sym_k`=1, `sym_err`=0) opens a frame at position 0 and restarts the checksum. `seed_restart` is high for exactly the one cycle after that symbol is accepted.
- R3: A control symbol with byte 0xFB puts an open frame back at position 0 and restarts the checksum, and it does not pulse `seed_restart`. When no frame is open, it has no effect: data that follows is still discarded.
- R4: Any control byte other than 0x3C and 0xFB closes the frame, and the data that follows is discarded.
- R5: A data byte that arrives while no frame is open is dropped. It changes no output and no counter.
- R6: When the last byte of a packet is stored, `pkt_ready` rises in the next cycle. It stays high until a cycle with `rdy_ack` high, and it falls in the cycle after that.
- R7: The checksum is CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion. It covers every byte before the last four. The last four bytes hold the checksum, least significant byte first. `pkt_crc_ok` shows the result of the comparison and changes together with `pkt_ready`.
- R8: On a match, `led_level` takes packet byte `MOD_ADDR/2`: its upper nibble when `MOD_ADDR` is odd, its lower nibble when it is even. `chan_mask` takes packet byte `ceil(NUM_MOD/2)+MOD_ADDR`.
- R9: On a mismatch, `crc_err_cnt` increments by one and `led_level` and `chan_mask` keep their values.
- R10: A data byte that arrives while `pkt_ready` is high closes the frame and increments `proc_ovf_cnt`. `pkt_ready` stays high.
- R11: A data byte that arrives in an open frame that already holds a full packet, with `pkt_ready` low, closes the frame and increments `rx_ovf_cnt`.
- R12: A valid symbol with `sym_err` high increments `dec_err_cnt` and leaves the frame position unchanged, so a packet interrupted by one such symbol still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_k | input | 1 | Symbol is a control code |
| sym_err | input | 1 | Decoder found the symbol invalid |
| sym_byte | input | 8 | Data byte or control-code byte |
| rdy_ack | input | 1 | Consumer acknowledges the ready packet |
| pkt_ready | output | 1 | A complete packet waits for acknowledge |
| pkt_crc_ok | output | 1 | Checksum result of the last packet |
| seed_restart | output | 1 | One-cycle pulse: descrambler should reseed |
| led_level | output | 4 | Brightness nibble for this module |
| chan_mask | output | 8 | Channel mask for this module |
| crc_err_cnt | output | CNT_W | Checksum mismatches |
| rx_ovf_cnt | output | CNT_W | Bytes beyond a full, acknowledged frame |
| proc_ovf_cnt | output | CNT_W | Bytes arriving while a packet is unacknowledged |
| dec_err_cnt | output | CNT_W | Decoder-reported invalid symbols |

## Verification
A wrong frame position shows up at the ports one packet later. `pkt_ready` rises early or late, or never rises, and a wrong checksum base makes `pkt_crc_ok` fall and `crc_err_cnt` climb on a packet that is known to be good. A wrong capture index or nibble select shows up one cycle after the last byte as a wrong `led_level` or `chan_mask`. Checking two address parities against the same stream separates these faults. Each framing fault (an ignored resync, a frame that fails to close, a dropped overflow) shows up as a ready flag or counter that differs from the expected one in the cycle after the symbol that caused it.

// File: rtl/kfr_pkg.sv
package kfr_pkg;
  localparam logic [7:0]  K_OPEN   = 8'h3C;
  localparam logic [7:0]  K_RESYNC = 8'hFB;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam int          CRC_LEN  = 4;

  typedef enum logic [1:0] {SYM_IDLE, SYM_DATA, SYM_CTRL, SYM_BAD} sym_kind_e;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/kfr_evcnt.sv
module kfr_evcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (inc && ~&cnt)    cnt <= cnt + W'(1);
  end

  // R9 R10 R11 R12
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && ~&cnt) |=> cnt == $past(cnt) + W'(1));

  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/kfr_crc32.sv
module kfr_crc32 (
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  data,
  output logic [31:0] state
);
  always_ff @(posedge clk) begin
    if (rst || init) state <= 32'hFFFF_FFFF;
    else if (upd)    state <= kfr_pkg::crc_step(state, data);
  end
endmodule

// File: rtl/kfr_framer.sv
module kfr_framer
  import kfr_pkg::*;
#(
  parameter int PKT_BYTES = 16,
  parameter int IDX_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic             sym_k,
  input  logic             sym_err,
  input  logic [7:0]       sym_byte,
  input  logic             rdy_ack,
  output logic             store_en,
  output logic [IDX_W-1:0] store_idx,
  output logic             crc_init,
  output logic             done,
  output logic             pkt_ready,
  output logic             seed_restart,
  output logic             ev_dec,
  output logic             ev_proc,
  output logic             ev_rx
);
  localparam logic [IDX_W-1:0] FULL = IDX_W'(PKT_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_BYTES - 1);

  sym_kind_e        kind;
  logic             open_q;
  logic [IDX_W-1:0] idx_q;
  logic             start, resync, close_k, data_in;

  always_comb begin
    if (!sym_valid)   kind = SYM_IDLE;
    else if (sym_err) kind = SYM_BAD;
    else if (sym_k)   kind = SYM_CTRL;
    else              kind = SYM_DATA;
  end

  assign start    = (kind == SYM_CTRL) && (sym_byte == K_OPEN);
  assign resync   = (kind == SYM_CTRL) && (sym_byte == K_RESYNC) && open_q;
  assign close_k  = (kind == SYM_CTRL) && (sym_byte != K_OPEN) && (sym_byte != K_RESYNC);
  assign data_in  = (kind == SYM_DATA) && open_q;
  assign ev_dec   = (kind == SYM_BAD);
  assign ev_proc  = data_in && pkt_ready;
  assign ev_rx    = data_in && !pkt_ready && (idx_q == FULL);
  assign store_en = data_in && !pkt_ready && (idx_q != FULL);
  assign store_idx = idx_q;
  assign done     = store_en && (idx_q == LAST);
  assign crc_init = start || resync;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      idx_q  <= '0;
    end else if (crc_init) begin
      open_q <= 1'b1;
      idx_q  <= '0;
    end else if (close_k || ev_proc || ev_rx) begin
      open_q <= 1'b0;
    end else if (store_en) begin
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_ready    <= 1'b0;
      seed_restart <= 1'b0;
    end else begin
      seed_restart <= start;
      if (done)         pkt_ready <= 1'b1;
      else if (rdy_ack) pkt_ready <= 1'b0;
    end
  end

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_ready && !rdy_ack) |=> pkt_ready);

  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_ready) |-> $past(sym_valid && !sym_k && !sym_err));

  // R2
  seed_src_chk: assert property (@(posedge clk) disable iff (rst)
    seed_restart |-> $past(sym_valid && sym_k && !sym_err && sym_byte == K_OPEN));

  // R11
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= FULL);
endmodule

// File: rtl/kfr_fields.sv
module kfr_fields
  import kfr_pkg::*;
#(
  parameter int PKT_BYTES = 16,
  parameter int BR_IDX    = 2,
  parameter bit BR_HI     = 1'b1,
  parameter int CH_IDX    = 9,
  parameter int IDX_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             store_en,
  input  logic [IDX_W-1:0] store_idx,
  input  logic [7:0]       sym_byte,
  input  logic             done,
  input  logic [31:0]      crc_state,
  output logic [3:0]       led_level,
  output logic [7:0]       chan_mask,
  output logic             crc_ok,
  output logic             ev_crc
);
  localparam int CRC_OFS = PKT_BYTES - CRC_LEN;

  logic [7:0]  br_sh, ch_sh;
  logic [7:0]  crc_sh [CRC_LEN-1];
  logic [3:0]  nib;
  logic [31:0] rx_crc;
  logic        match;

  always_ff @(posedge clk) begin
    if (rst) begin
      br_sh <= '0;
      ch_sh <= '0;
    end else if (store_en) begin
      if (store_idx == IDX_W'(BR_IDX)) br_sh <= sym_byte;
      if (store_idx == IDX_W'(CH_IDX)) ch_sh <= sym_byte;
    end
  end

  for (genvar g = 0; g < CRC_LEN - 1; g++) begin : g_crcb
    always_ff @(posedge clk) begin
      if (rst)
        crc_sh[g] <= '0;
      else if (store_en && store_idx == IDX_W'(CRC_OFS + g))
        crc_sh[g] <= sym_byte;
    end
  end

  if (BR_HI) begin : g_hi
    assign nib = br_sh[7:4];
  end else begin : g_lo
    assign nib = br_sh[3:0];
  end

  assign rx_crc = {sym_byte, crc_sh[2], crc_sh[1], crc_sh[0]};
  assign match  = (~crc_state == rx_crc);
  assign ev_crc = done && !match;

  always_ff @(posedge clk) begin
    if (rst) begin
      led_level <= '0;
      chan_mask <= '0;
      crc_ok    <= 1'b0;
    end else if (done) begin
      crc_ok <= match;
      if (match) begin
        led_level <= nib;
        chan_mask <= ch_sh;
      end
    end
  end

  // R9
  keep_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
    !crc_ok |-> ($stable(chan_mask) && $stable(led_level)));

  // R8
  upd_only_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_mask) |-> $past(done));
endmodule

// File: rtl/kframe_rx.sv
module kframe_rx #(
  parameter int NUM_MOD  = 8,
  parameter int MOD_ADDR = 5,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic             sym_k,
  input  logic             sym_err,
  input  logic [7:0]       sym_byte,
  input  logic             rdy_ack,
  output logic             pkt_ready,
  output logic             pkt_crc_ok,
  output logic             seed_restart,
  output logic [3:0]       led_level,
  output logic [7:0]       chan_mask,
  output logic [CNT_W-1:0] crc_err_cnt,
  output logic [CNT_W-1:0] rx_ovf_cnt,
  output logic [CNT_W-1:0] proc_ovf_cnt,
  output logic [CNT_W-1:0] dec_err_cnt
);
  localparam int BR_BYTES  = (NUM_MOD + 1) / 2;
  localparam int CRC_OFS   = BR_BYTES + NUM_MOD;
  localparam int PKT_BYTES = CRC_OFS + kfr_pkg::CRC_LEN;
  localparam int IDX_W     = $clog2(PKT_BYTES + 1);
  localparam int BR_IDX    = MOD_ADDR / 2;
  localparam bit BR_HI     = (MOD_ADDR % 2) == 1;
  localparam int CH_IDX    = BR_BYTES + MOD_ADDR;

  logic             store_en, crc_init, done;
  logic [IDX_W-1:0] store_idx;
  logic [31:0]      crc_state;
  logic             ev_dec, ev_proc, ev_rx, ev_crc;

  kfr_framer #(.PKT_BYTES(PKT_BYTES), .IDX_W(IDX_W)) u_framer (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_k(sym_k), .sym_err(sym_err),
    .sym_byte(sym_byte), .rdy_ack(rdy_ack), .store_en(store_en), .store_idx(store_idx),
    .crc_init(crc_init), .done(done), .pkt_ready(pkt_ready), .seed_restart(seed_restart),
    .ev_dec(ev_dec), .ev_proc(ev_proc), .ev_rx(ev_rx)
  );

  kfr_crc32 u_crc (
    .clk(clk), .rst(rst), .init(crc_init),
    .upd(store_en && (store_idx < IDX_W'(CRC_OFS))),
    .data(sym_byte), .state(crc_state)
  );

  kfr_fields #(.PKT_BYTES(PKT_BYTES), .BR_IDX(BR_IDX), .BR_HI(BR_HI),
               .CH_IDX(CH_IDX), .IDX_W(IDX_W)) u_fields (
    .clk(clk), .rst(rst), .store_en(store_en), .store_idx(store_idx),
    .sym_byte(sym_byte), .done(done), .crc_state(crc_state),
    .led_level(led_level), .chan_mask(chan_mask), .crc_ok(pkt_crc_ok), .ev_crc(ev_crc)
  );

  kfr_evcnt #(.W(CNT_W)) u_cnt_crc  (.clk(clk), .rst(rst), .inc(ev_crc),  .cnt(crc_err_cnt));
  kfr_evcnt #(.W(CNT_W)) u_cnt_rx   (.clk(clk), .rst(rst), .inc(ev_rx),   .cnt(rx_ovf_cnt));
  kfr_evcnt #(.W(CNT_W)) u_cnt_proc (.clk(clk), .rst(rst), .inc(ev_proc), .cnt(proc_ovf_cnt));
  kfr_evcnt #(.W(CNT_W)) u_cnt_dec  (.clk(clk), .rst(rst), .inc(ev_dec),  .cnt(dec_err_cnt));

  // R7
  ok_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pkt_crc_ok) |-> $rose(pkt_ready) || $past(pkt_ready && done));
endmodule

// File: tb/kframe_rx_bench.sv
module kframe_rx_bench;
  localparam int NM = 8;
  localparam int PL = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0, sym_k = 1'b0, sym_err = 1'b0, rdy_ack = 1'b0;
  logic [7:0] sym_byte = 8'h00;

  logic pkt_ready, pkt_crc_ok, seed_restart;
  logic [3:0] led_level;
  logic [7:0] chan_mask;
  logic [CW-1:0] crc_err_cnt, rx_ovf_cnt, proc_ovf_cnt, dec_err_cnt;
  logic e_ready, e_ok, e_seed;
  logic [3:0] e_led;
  logic [7:0] e_mask;
  logic [CW-1:0] e_c0, e_c1, e_c2, e_c3;

  kframe_rx #(.NUM_MOD(NM), .MOD_ADDR(5), .CNT_W(CW)) u_kframe_rx (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_k(sym_k), .sym_err(sym_err),
    .sym_byte(sym_byte), .rdy_ack(rdy_ack), .pkt_ready(pkt_ready), .pkt_crc_ok(pkt_crc_ok),
    .seed_restart(seed_restart), .led_level(led_level), .chan_mask(chan_mask),
    .crc_err_cnt(crc_err_cnt), .rx_ovf_cnt(rx_ovf_cnt), .proc_ovf_cnt(proc_ovf_cnt),
    .dec_err_cnt(dec_err_cnt)
  );

  kframe_rx #(.NUM_MOD(NM), .MOD_ADDR(2), .CNT_W(CW)) u_kframe_rx_even (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_k(sym_k), .sym_err(sym_err),
    .sym_byte(sym_byte), .rdy_ack(rdy_ack), .pkt_ready(e_ready), .pkt_crc_ok(e_ok),
    .seed_restart(e_seed), .led_level(e_led), .chan_mask(e_mask),
    .crc_err_cnt(e_c0), .rx_ovf_cnt(e_c1), .proc_ovf_cnt(e_c2), .dec_err_cnt(e_c3)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] pkt [PL];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ pkt[i][j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic make_pkt(input int seed);
    logic [31:0] c;
    for (int i = 0; i < PL - 4; i++) pkt[i] = 8'(seed * 29 + i * 13 + 7);
    c = ref_crc(PL - 4);
    for (int i = 0; i < 4; i++) pkt[PL - 4 + i] = c[8*i +: 8];
  endtask

  task automatic send(input logic k, input logic err, input logic [7:0] b);
    @(negedge clk);
    sym_valid = 1'b1; sym_k = k; sym_err = err; sym_byte = b;
    @(negedge clk);
    sym_valid = 1'b0; sym_k = 1'b0; sym_err = 1'b0;
  endtask

  task automatic send_body(input int first, input int last, input bit corrupt);
    for (int i = first; i <= last; i++)
      send(1'b0, 1'b0, (corrupt && i == PL - 1) ? pkt[i] ^ 8'h01 : pkt[i]);
  endtask

  task automatic ack();
    @(negedge clk); rdy_ack = 1'b1;
    @(negedge clk); rdy_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready", pkt_ready, 0);
    check("R1 crc_ok", pkt_crc_ok, 0);
    check("R1 seed", seed_restart, 0);
    check("R1 led", led_level, 0);
    check("R1 mask", chan_mask, 0);
    check("R1 counters", {crc_err_cnt, rx_ovf_cnt, proc_ovf_cnt, dec_err_cnt} == '0, 1);
  endtask

  task automatic t_good();
    make_pkt(1);
    send(1'b1, 1'b0, 8'h3C);
    check("R2 seed pulse", seed_restart, 1);
    send_body(0, 0, 0);
    check("R2 seed one cycle", seed_restart, 0);
    send_body(1, PL - 1, 0);
    check("R6 ready", pkt_ready, 1);
    check("R7 crc ok", pkt_crc_ok, 1);
    check("R8 led odd", led_level, pkt[2][7:4]);
    check("R8 mask odd", chan_mask, pkt[9]);
    check("R8 led even", e_led, pkt[1][3:0]);
    check("R8 mask even", e_mask, pkt[6]);
    repeat (3) @(negedge clk);
    check("R6 ready held", pkt_ready, 1);
    ack();
    check("R6 ready cleared", pkt_ready, 0);
  endtask

  task automatic t_badcrc();
    logic [7:0] m0 = chan_mask;
    logic [3:0] l0 = led_level;
    make_pkt(2);
    send(1'b1, 1'b0, 8'h3C);
    send_body(0, PL - 1, 1);
    check("R9 ready", pkt_ready, 1);
    check("R7 crc bad", pkt_crc_ok, 0);
    check("R9 crc count", crc_err_cnt, 1);
    check("R9 mask kept", chan_mask, m0);
    check("R9 led kept", led_level, l0);
    ack();
  endtask

  task automatic t_proc_ovf();
    logic [7:0] mb;
    make_pkt(3);
    mb = pkt[9];
    send(1'b1, 1'b0, 8'h3C);
    send_body(0, PL - 1, 0);
    send(1'b0, 1'b0, 8'h55);
    check("R10 proc count", proc_ovf_cnt, 1);
    check("R10 ready stays", pkt_ready, 1);
    ack();
    make_pkt(4);
    send(1'b1, 1'b0, 8'hFB);
    send_body(0, PL - 1, 0);
    check("R3 resync closed no effect", pkt_ready, 0);
    check("R5 mask unchanged", chan_mask, mb);
    check("R5 rx count", rx_ovf_cnt, 0);
  endtask

  task automatic t_rx_ovf();
    make_pkt(5);
    send(1'b1, 1'b0, 8'h3C);
    send_body(0, PL - 1, 0);
    ack();
    send(1'b0, 1'b0, 8'h66);
    check("R11 rx count", rx_ovf_cnt, 1);
    check("R11 mask", chan_mask, pkt[9]);
    send(1'b0, 1'b0, 8'h67);
    check("R5 closed no count", rx_ovf_cnt, 1);
    check("R5 proc no count", proc_ovf_cnt, 1);
  endtask

  task automatic t_resync();
    make_pkt(6);
    send(1'b1, 1'b0, 8'h3C);
    for (int i = 0; i < 5; i++) send(1'b0, 1'b0, 8'hAA);
    send(1'b1, 1'b0, 8'hFB);
    check("R3 no seed pulse", seed_restart, 0);
    send_body(0, PL - 1, 0);
    check("R3 ready", pkt_ready, 1);
    check("R3 crc ok", pkt_crc_ok, 1);
    check("R3 mask", chan_mask, pkt[9]);
    ack();
  endtask

  task automatic t_other_k();
    logic [7:0] md = chan_mask;
    make_pkt(7);
    send(1'b1, 1'b0, 8'h3C);
    send_body(0, 4, 0);
    send(1'b1, 1'b0, 8'hBC);
    send_body(0, PL - 1, 0);
    check("R4 no ready", pkt_ready, 0);
    check("R4 mask kept", chan_mask, md);
  endtask

  task automatic t_dec_err();
    make_pkt(8);
    send(1'b1, 1'b0, 8'h3C);
    send_body(0, 7, 0);
    send(1'b0, 1'b1, 8'h00);
    check("R12 dec count", dec_err_cnt, 1);
    send_body(8, PL - 1, 0);
    check("R12 ready", pkt_ready, 1);
    check("R12 crc ok", pkt_crc_ok, 1);
    check("R12 mask", chan_mask, pkt[9]);
    check("R9 crc count total", crc_err_cnt, 1);
    ack();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good();
    t_badcrc();
    t_proc_ovf();
    t_rx_ovf();
    t_resync();
    t_other_k();
    t_dec_err();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule